// File: doc/BRIEF.md
# Flash Prefetch Line Buffer

This block sits between a 32-bit read requester and a slow flash array whose read port returns a whole 128-bit line at a time. It keeps a few 16-byte lines so that reads to a line already held, or to the line that sequential code is about to reach, do not pay the flash wait states. Each request carries a two-bit source tag: CPU instruction fetch, CPU constant-data read, or peripheral read (any non-CPU master such as a DMA engine).

Four lines can be allocated: one for instruction fetches, one for CPU data, and two shared by peripherals, with the peripheral pair replaced least-recently-used. A two-bit allocation mode chooses which categories may allocate. Matching uses only the line address, so a line filled by one source type serves all the others. When prefetch is on, an instruction access to line L starts a background read of line L+1 into a staging entry. A later hit on the staging entry moves that line into the instruction line. A three-bit wait-state count sets the length of every flash access. Only one flash access is in flight at any time. A flush input discards every held line.

Top module: `flash_linebuf`

## Requirements
- R1: Reset leaves req_ready high, rsp_valid and fl_rd low, and every line invalid, so the first read is a miss.
- R2: A read to a line not held, accepted at clock edge T, drives fl_rd with fl_line = req_addr[31:4] and keeps fl_line stable. It holds req_ready low and raises rsp_valid with the addressed word after edge T+W+1, where W = cfg_ws.
- R3: A read that hits raises rsp_valid after the accepting edge itself, with no wait states. The word comes from address bits [3:2], and word k is line bits [32k+31:32k].
- R4: Hit matching compares only address bits [31:4]. A line filled by any source (req_src 00 instruction, 01 data, 1x peripheral) serves reads from every source, and no address ever matches two lines.
- R5: cfg_alloc 00 disables every line, so there are no hits and nothing is stored. 01 lets only instruction misses allocate, 10 lets instruction and data misses allocate, and 11 lets all sources allocate. A miss from a disabled category still returns flash data.
- R6: A peripheral miss replaces whichever of the two peripheral lines was not most recently filled or hit.
- R7: With cfg_pf_en = 1 and cfg_alloc not 00, an instruction access to line L starts a background fetch of L+1 unless L+1 is already held. Straight-line instruction fetches therefore wait only on the first word of the first line.
- R8: A demand miss to a different line abandons a background fetch and restarts with full latency. A demand miss to the line being fetched in the background takes over that access and completes when it does.
- R9: A flush invalidates every line and abandons a background fetch, so the next read of a previously held line is a miss that returns current flash contents.
- R10: At most one flash access is active, and during a demand fill fl_rd stays high until the data is taken.
- R11: With cfg_pf_en = 0, no background fetch happens, and the first read of the next line is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines, abandon background fetch |
| cfg_ws | input | 3 | Flash wait states per line read |
| cfg_alloc | input | 2 | Allocation mode (00 off, 01 instr, 10 instr+data, 11 all) |
| cfg_pf_en | input | 1 | Sequential next-line prefetch enable |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_addr | input | 32 | Byte address of the read |
| req_src | input | 2 | Source: 00 instruction, 01 CPU data, 1x peripheral |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Read word |
| fl_rd | output | 1 | Flash access active |
| fl_line | output | 28 | Flash line address (byte address bits [31:4]) |
| fl_data | input | 128 | Flash line data, taken when the wait count expires |

## Verification
The hardest case to reach is a demand read that arrives while a background fetch is still running. It must either take over that access or abandon it, and the result is visible only as a response latency that differs from both a hit and a full miss. The bench sets a long wait count and issues a fetch right after an instruction fill, once to the line being prefetched and once to an unrelated line. It then re-reads the abandoned line to show that nothing was stored. Stale data after a flush is exposed by changing a generation field in the flash model, so a held line returns old contents and a refetched line returns new ones.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int NUM_ENT = 5;
  localparam int IDX_W   = 3;

  localparam logic [IDX_W-1:0] IDX_INSN  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_DATA  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_PER0  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_PER1  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_STAGE = 3'd4;

  localparam logic [1:0] SRC_INSN = 2'b00;
  localparam logic [1:0] SRC_DATA = 2'b01;
endpackage

// File: rtl/fpb_tag_match.sv
module fpb_tag_match #(
  parameter int TAG_W = 28,
  parameter int N     = 5
) (
  input  logic [TAG_W-1:0]         key,
  input  logic [N-1:0][TAG_W-1:0]  tags,
  input  logic [N-1:0]             valid,
  output logic [N-1:0]             hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/fpb_alloc.sv
module fpb_alloc
  import fpb_pkg::*;
(
  input  logic [1:0]       src,
  input  logic [1:0]       mode,
  input  logic             mru_hi,
  output logic             ok,
  output logic [IDX_W-1:0] victim
);
  always_comb begin
    ok     = 1'b0;
    victim = IDX_INSN;
    if (src[1]) begin
      ok     = (mode == 2'b11);
      victim = mru_hi ? IDX_PER0 : IDX_PER1;
    end else if (src[0]) begin
      ok     = mode[1];
      victim = IDX_DATA;
    end else begin
      ok     = |mode;
      victim = IDX_INSN;
    end
  end
endmodule

// File: rtl/fpb_word_sel.sv
module fpb_word_sel #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic [WORD_W*WORDS-1:0] line,
  input  logic [OFF_W-1:0]        sel,
  output logic [WORD_W-1:0]       word
);
  logic [WORD_W-1:0] lanes [WORDS];
  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign lanes[g] = line[g*WORD_W +: WORD_W];
  end
  assign word = lanes[sel];
endmodule

// File: rtl/flash_linebuf.sv
module flash_linebuf
  import fpb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int WS_W   = 3,
  localparam int LINE_W   = WORD_W * WORDS,
  localparam int OFF_W    = $clog2(WORDS),
  localparam int BYTE_OFF = $clog2(WORD_W / 8),
  localparam int TAG_W    = ADDR_W - OFF_W - BYTE_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [WS_W-1:0]   cfg_ws,
  input  logic [1:0]        cfg_alloc,
  input  logic              cfg_pf_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_src,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              fl_rd,
  output logic [TAG_W-1:0]  fl_line,
  input  logic [LINE_W-1:0] fl_data
);
  localparam int N = NUM_ENT;

  // line state
  logic [N-1:0][TAG_W-1:0] tag_q;
  logic [N-1:0]            valid_q;
  logic [LINE_W-1:0]       mem_q [N];
  logic                    mru_q;

  // flash engine state
  logic             eng_busy, eng_pf, keep_q;
  logic [WS_W-1:0]  eng_cnt;
  logic [TAG_W-1:0] eng_tag;
  logic [1:0]       eng_src;
  logic [OFF_W-1:0] eng_off;

  logic [TAG_W-1:0] req_tag, nxt_tag;
  logic [OFF_W-1:0] req_off, cap_off;
  logic [1:0]       cap_src;
  logic [N-1:0]     hit_vec, nxt_vec;
  logic [IDX_W-1:0] hit_idx, cap_vic;
  logic             hit_any, accept, done, conv, dem_done, pf_done;
  logic             cap_ok, pf_launch, nxt_present;
  logic [WORD_W-1:0] hit_word, fl_word;
  logic             unused_bits;

  assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign req_off     = req_addr[BYTE_OFF +: OFF_W];
  assign unused_bits = ^req_addr[BYTE_OFF-1:0];

  fpb_tag_match #(.TAG_W(TAG_W), .N(N)) u_hit (
    .key(req_tag), .tags(tag_q), .valid(valid_q), .hit(hit_vec)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any   = (|hit_vec) && (cfg_alloc != 2'b00);
  assign req_ready = !flush && !(eng_busy && !eng_pf);
  assign accept    = req_valid && req_ready;
  assign done      = eng_busy && (eng_cnt == '0);
  assign conv      = accept && !hit_any && eng_busy && eng_pf && (eng_tag == req_tag);
  assign dem_done  = done && (!eng_pf || conv);
  assign pf_done   = done && eng_pf && !conv;
  assign cap_src   = conv ? req_src : eng_src;
  assign cap_off   = conv ? req_off : eng_off;

  fpb_alloc u_alloc (
    .src(cap_src), .mode(cfg_alloc), .mru_hi(mru_q), .ok(cap_ok), .victim(cap_vic)
  );

  fpb_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_hit_sel (
    .line(mem_q[hit_idx]), .sel(req_off), .word(hit_word)
  );

  fpb_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_fl_sel (
    .line(fl_data), .sel(cap_off), .word(fl_word)
  );

  // next-line presence check for prefetch
  assign nxt_tag = accept ? (req_tag + TAG_W'(1)) : (eng_tag + TAG_W'(1));

  fpb_tag_match #(.TAG_W(TAG_W), .N(N)) u_nxt (
    .key(nxt_tag), .tags(tag_q), .valid(valid_q), .hit(nxt_vec)
  );

  assign nxt_present = (|nxt_vec) || (pf_done && (nxt_tag == eng_tag));

  assign pf_launch = cfg_pf_en && (cfg_alloc != 2'b00) && !flush && !nxt_present &&
                     ((accept && hit_any && (req_src == SRC_INSN) && (!eng_busy || pf_done)) ||
                      (dem_done && (cap_src == SRC_INSN)));

  assign fl_rd   = eng_busy;
  assign fl_line = eng_tag;

  // control and tag state
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      tag_q     <= '0;
      mru_q     <= 1'b0;
      eng_busy  <= 1'b0;
      eng_pf    <= 1'b0;
      keep_q    <= 1'b0;
      eng_cnt   <= '0;
      eng_tag   <= '0;
      eng_src   <= SRC_INSN;
      eng_off   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;

      // hit path, including staging promotion
      if (accept && hit_any) begin
        rsp_valid <= 1'b1;
        rsp_data  <= hit_word;
        if (hit_idx == IDX_STAGE) begin
          valid_q[IDX_STAGE] <= 1'b0;
          valid_q[IDX_INSN]  <= 1'b1;
          tag_q[IDX_INSN]    <= tag_q[IDX_STAGE];
        end
        if (hit_idx == IDX_PER0) mru_q <= 1'b0;
        if (hit_idx == IDX_PER1) mru_q <= 1'b1;
      end

      // flash engine countdown and capture
      if (eng_busy && !done) eng_cnt <= eng_cnt - WS_W'(1);
      if (done) begin
        eng_busy <= 1'b0;
        if (dem_done) begin
          rsp_valid <= 1'b1;
          rsp_data  <= fl_word;
          if (keep_q && cap_ok) begin
            valid_q[cap_vic] <= 1'b1;
            tag_q[cap_vic]   <= eng_tag;
            if (cap_vic == IDX_PER0) mru_q <= 1'b0;
            if (cap_vic == IDX_PER1) mru_q <= 1'b1;
          end
        end else if (keep_q) begin
          valid_q[IDX_STAGE] <= 1'b1;
          tag_q[IDX_STAGE]   <= eng_tag;
        end
      end

      // demand miss: take over or (re)start the engine
      if (accept && !hit_any) begin
        eng_pf  <= 1'b0;
        eng_src <= req_src;
        eng_off <= req_off;
        if (!conv) begin
          eng_busy <= 1'b1;
          eng_cnt  <= cfg_ws;
          eng_tag  <= req_tag;
          keep_q   <= 1'b1;
        end
      end

      if (pf_launch) begin
        eng_busy <= 1'b1;
        eng_pf   <= 1'b1;
        eng_cnt  <= cfg_ws;
        eng_tag  <= nxt_tag;
        eng_src  <= SRC_INSN;
        keep_q   <= 1'b1;
      end

      if (flush) begin
        valid_q <= '0;
        if (eng_busy && eng_pf)  eng_busy <= 1'b0;
        if (eng_busy && !eng_pf) keep_q   <= 1'b0;
      end
    end
  end

  // line data, no reset
  always_ff @(posedge clk) begin
    if (accept && hit_any && (hit_idx == IDX_STAGE)) mem_q[IDX_INSN] <= mem_q[IDX_STAGE];
    if (dem_done && keep_q && cap_ok) mem_q[cap_vic] <= fl_data;
    if (pf_done && keep_q) mem_q[IDX_STAGE] <= fl_data;
  end
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int TAG_W = 28,
  parameter int WS_W  = 3,
  parameter int N     = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             req_valid,
  input logic             req_ready,
  input logic             hit_any,
  input logic [N-1:0]     hit_vec,
  input logic [N-1:0]     valid_q,
  input logic             eng_busy,
  input logic             eng_pf,
  input logic [WS_W-1:0]  eng_cnt,
  input logic             fl_rd,
  input logic [TAG_W-1:0] fl_line,
  input logic             rsp_valid
);
  AST_HIT_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit_any) |=> rsp_valid); // R3

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0)); // R9

  AST_DEMAND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && !eng_pf) |-> !req_ready); // R2

  AST_LINE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && !eng_pf && (eng_cnt != '0)) |=> (fl_rd && $stable(fl_line))); // R10
endmodule

bind flash_linebuf fpb_checker #(.TAG_W(TAG_W), .WS_W(WS_W), .N(fpb_pkg::NUM_ENT)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
  .hit_any(hit_any), .hit_vec(hit_vec), .valid_q(valid_q), .eng_busy(eng_busy),
  .eng_pf(eng_pf), .eng_cnt(eng_cnt), .fl_rd(fl_rd), .fl_line(fl_line), .rsp_valid(rsp_valid)
);

// File: tb/flash_linebuf_tb.sv
module flash_linebuf_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic [2:0]   cfg_ws = 3'd2;
  logic [1:0]   cfg_alloc = 2'b11;
  logic         cfg_pf_en = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [1:0]   req_src = 2'b00;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         fl_rd;
  logic [27:0]  fl_line;
  logic [127:0] fl_data;
  logic [1:0]   gen = 2'b00;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_linebuf u_dut (
    .clk(clk), .rst(rst), .flush(flush), .cfg_ws(cfg_ws), .cfg_alloc(cfg_alloc),
    .cfg_pf_en(cfg_pf_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_src(req_src), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fl_rd(fl_rd), .fl_line(fl_line), .fl_data(fl_data)
  );

  // flash model: word k of line L is {gen, L, k}
  always_comb begin
    for (int k = 0; k < 4; k++) fl_data[k*32 +: 32] = {gen, fl_line, 2'(k)};
  end

  function automatic logic [31:0] expw(input logic [31:0] a, input logic [1:0] g);
    return {g, a[31:2]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] s,
                    output int lat, output logic [31:0] d);
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    req_addr  = a;
    req_src   = s;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && guard < 1000) begin @(negedge clk); lat++; guard++; end
    d = rsp_data;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [1:0] s,
                        input int exp_lat, input logic [31:0] exp_d);
    int lat;
    logic [31:0] d;
    rd(a, s, lat, d);
    check({req, " latency"}, 32'(lat), 32'(exp_lat));
    check({req, " data"}, d, exp_d);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // {alloc, src, addr, latency}; W=2: miss latency 4, hit latency 1
  localparam logic [39:0] VEC [16] = '{
    {2'b11, 2'b00, 32'h0000_1000, 4'd4},  // R2 first read misses
    {2'b11, 2'b00, 32'h0000_1004, 4'd1},  // R3 word 1
    {2'b11, 2'b00, 32'h0000_100C, 4'd1},  // R3 word 3
    {2'b11, 2'b01, 32'h0000_1008, 4'd1},  // R4 data hits instr-filled line
    {2'b11, 2'b10, 32'h0000_1000, 4'd1},  // R4 peripheral hits it too
    {2'b11, 2'b01, 32'h0000_2004, 4'd4},  // R2 data miss
    {2'b11, 2'b00, 32'h0000_2000, 4'd1},  // R4 instr hits data line
    {2'b00, 2'b00, 32'h0000_1000, 4'd4},  // R5 mode 00: no hits
    {2'b01, 2'b01, 32'h0000_3000, 4'd4},  // R5 mode 01: data miss
    {2'b01, 2'b01, 32'h0000_3000, 4'd4},  // R5 mode 01: data not stored
    {2'b10, 2'b01, 32'h0000_3000, 4'd4},  // R5 mode 10: data stored
    {2'b10, 2'b01, 32'h0000_3008, 4'd1},  // R5 mode 10: data hit
    {2'b10, 2'b10, 32'h0000_4000, 4'd4},  // R5 mode 10: peripheral miss
    {2'b10, 2'b10, 32'h0000_4000, 4'd4},  // R5 mode 10: peripheral not stored
    {2'b11, 2'b00, 32'h0000_1008, 4'd1},  // R5 instr line survived mode 00 miss
    {2'b11, 2'b00, 32'h0000_2000, 4'd4}   // R5 data line replaced earlier
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 fl_rd", 32'(fl_rd), 32'd0);

    // table: W=2, prefetch off
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a;
      int lat;
      logic [31:0] d;
      a = VEC[i][35:4];
      @(negedge clk);
      cfg_alloc = VEC[i][39:38];
      rd(a, VEC[i][37:36], lat, d);
      check($sformatf("vector %0d latency", i), 32'(lat), 32'(VEC[i][3:0]));
      check($sformatf("vector %0d data", i), d, expw(a, gen));
    end

    // R6 peripheral LRU
    cfg_alloc = 2'b11;
    do_flush();
    rd_chk("R6 A", 32'h0000_B000, 2'b10, 4, expw(32'h0000_B000, gen));
    rd_chk("R6 B", 32'h0000_C000, 2'b10, 4, expw(32'h0000_C000, gen));
    rd_chk("R6 A hit", 32'h0000_B004, 2'b10, 1, expw(32'h0000_B004, gen));
    rd_chk("R6 C replaces B", 32'h0000_D000, 2'b11, 4, expw(32'h0000_D000, gen));
    rd_chk("R6 A kept", 32'h0000_B008, 2'b10, 1, expw(32'h0000_B008, gen));
    rd_chk("R6 B gone", 32'h0000_C000, 2'b10, 4, expw(32'h0000_C000, gen));
    rd_chk("R6 A kept again", 32'h0000_B00C, 2'b10, 1, expw(32'h0000_B00C, gen));
    rd_chk("R6 C gone", 32'h0000_D004, 2'b10, 4, expw(32'h0000_D004, gen));

    // R11 no prefetch when disabled
    do_flush();
    rd_chk("R11 first", 32'h0000_6000, 2'b00, 4, expw(32'h0000_6000, gen));
    @(negedge clk);
    check("R11 flash idle", 32'(fl_rd), 32'd0);
    rd_chk("R11 next line misses", 32'h0000_6010, 2'b00, 4, expw(32'h0000_6010, gen));

    // R7 sequential prefetch, W=2
    cfg_pf_en = 1'b1;
    do_flush();
    rd_chk("R7 first word", 32'h0000_5000, 2'b00, 4, expw(32'h0000_5000, gen));
    for (int k = 1; k < 12; k++) begin
      logic [31:0] a;
      a = 32'h0000_5000 + 32'(k * 4);
      rd_chk($sformatf("R7 word %0d", k), a, 2'b00, 1, expw(a, gen));
    end

    // R8 take-over and abort, W=7
    cfg_ws = 3'd7;
    do_flush();
    rd_chk("R8 fill", 32'h0000_7000, 2'b00, 9, expw(32'h0000_7000, gen));
    rd_chk("R8 take over prefetch", 32'h0000_7010, 2'b00, 7, expw(32'h0000_7010, gen));
    do_flush();
    rd_chk("R8 fill 2", 32'h0000_8000, 2'b00, 9, expw(32'h0000_8000, gen));
    rd_chk("R8 abort for other line", 32'h0000_9000, 2'b00, 9, expw(32'h0000_9000, gen));
    rd_chk("R8 aborted line not held", 32'h0000_8010, 2'b00, 9, expw(32'h0000_8010, gen));

    // R9 flush
    cfg_ws = 3'd2;
    cfg_pf_en = 1'b0;
    do_flush();
    rd_chk("R9 fill", 32'h0000_A000, 2'b01, 4, expw(32'h0000_A000, 2'b00));
    gen = 2'b01;
    rd_chk("R9 stale hit", 32'h0000_A004, 2'b01, 1, expw(32'h0000_A004, 2'b00));
    do_flush();
    rd_chk("R9 miss after flush", 32'h0000_A004, 2'b01, 4, expw(32'h0000_A004, 2'b01));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule